// File: doc/BRIEF.md
# MSI message generator

This block turns interrupt requests of a function into Message Signaled Interrupt writes. It receives the message control fields, the message address registers and the two possible message data registers of the function's MSI capability. When an interrupt request names a vector, the block forms a message address and a data word. It then presents one posted 32-bit memory write on a valid/ready write-request port.

The capability can use 32-bit or 64-bit addressing, and the 64-bit form moves the data word to a different register. The block selects both the address width and the data register from the 64-bit field. With several vectors enabled, the vector number is merged into the low bits of the data word. Requests that arrive while a write is still waiting for acceptance are remembered in one pending flag per vector. They are then issued lowest vector first.

Top module: `msi_msg_gen`

## Requirements
- R1: After reset, wr_valid is low and no write is issued until a request is accepted.
- R2: While ctl_msi_en is 0, requests are ignored and no write is issued.
- R3: When ctl_addr64 is 1, wr_addr is {msg_addr_hi, msg_addr_lo}, wr_is64 is 1, and the data word comes from cap_data_w12.
- R4: When ctl_addr64 is 0, wr_addr is msg_addr_lo zero-extended to 64 bits, wr_is64 is 0, and the data word comes from cap_data_w8.
- R5: The enabled vector count is 2 to the power ctl_mme. Any ctl_mme value above 5 gives 32 vectors.
- R6: When the enabled count N is greater than one, wr_data[15:0] is the programmed data word with its low log2(N) bits replaced by the vector number.
- R7: When only one vector is enabled (ctl_mme = 0), wr_data[15:0] is the programmed data word unmodified.
- R8: A request whose vector is greater than or equal to the enabled count is ignored.
- R9: wr_data is the 16-bit data word zero-extended, so wr_data[31:16] is 0.
- R10: Once wr_valid is high, it stays high with wr_addr, wr_data and wr_is64 unchanged until a cycle with wr_ready high. Each such cycle completes exactly one write.
- R11: Each vector has a one-deep pending flag. Repeated requests for a vector that is already pending produce a single write.
- R12: Pending vectors are issued in ascending vector order, one write per vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_msi_en | input | 1 | MSI enable field of message control |
| ctl_addr64 | input | 1 | 64-bit address capable field of message control |
| ctl_mme | input | 3 | Multiple-message-enable field (log2 of enabled vectors) |
| msg_addr_lo | input | 32 | Message address, low 32 bits |
| msg_addr_hi | input | 32 | Message address, high 32 bits (64-bit form only) |
| cap_data_w8 | input | 16 | Message data register of the 32-bit capability layout |
| cap_data_w12 | input | 16 | Message data register of the 64-bit capability layout |
| irq_req | input | 1 | Interrupt request strobe, one request per cycle |
| irq_vec | input | VEC_W | Vector number of the request |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write request accepted when high with wr_valid |
| wr_addr | output | 64 | Write address |
| wr_data | output | 32 | Write data, little-endian dword |
| wr_is64 | output | 1 | Address uses the 64-bit form |

## Verification
The hardest situation to reach is a set of requests that pile up behind a write that has not been accepted. Only then do the per-vector merging and the ascending issue order have any effect. The stimulus holds wr_ready low after a first request, so the first message stays outstanding. It then sends a burst of further requests with repeats and out-of-range vectors, and afterwards releases wr_ready in a random pattern. The messages collected must match the list that the bench's own model predicts, in that order.

// File: rtl/msi_pkg.sv
package msi_pkg;

  typedef struct packed {
    logic [63:0] addr;
    logic [31:0] data;
    logic        is64;
  } msi_msg_t;

  // Replace the low log2n bits of the programmed data word with the vector.
  function automatic logic [15:0] msi_merge_vec(input logic [15:0] base,
                                                input int unsigned log2n,
                                                input logic [15:0] vec);
    logic [15:0] low_mask;
    low_mask = 16'((32'd1 << log2n) - 32'd1);
    return (base & ~low_mask) | (vec & low_mask);
  endfunction

  // Address width follows the capability's 64-bit field.
  function automatic logic [63:0] msi_address(input logic is64,
                                              input logic [31:0] lo,
                                              input logic [31:0] hi);
    return is64 ? {hi, lo} : {32'd0, lo};
  endfunction

  function automatic msi_msg_t msi_form(input logic is64,
                                        input logic [31:0] lo,
                                        input logic [31:0] hi,
                                        input logic [15:0] d_narrow,
                                        input logic [15:0] d_wide,
                                        input int unsigned log2n,
                                        input logic [15:0] vec);
    msi_msg_t m;
    m.addr = msi_address(is64, lo, hi);
    m.data = {16'd0, msi_merge_vec(is64 ? d_wide : d_narrow, log2n, vec)};
    m.is64 = is64;
    return m;
  endfunction

endpackage

// File: rtl/msi_cap_decode.sv
module msi_cap_decode #(
  parameter int VEC_W = 5,
  localparam int L2_W = $clog2(VEC_W + 1)
) (
  input  logic             ctl_msi_en,
  input  logic [2:0]       ctl_mme,
  input  logic             irq_req,
  input  logic [VEC_W-1:0] irq_vec,
  output logic [L2_W-1:0]  log2n,
  output logic [VEC_W:0]   vec_lim,
  output logic             req_accept
);

  always_comb begin
    if (int'(ctl_mme) > VEC_W) log2n = L2_W'(VEC_W);
    else                       log2n = L2_W'(ctl_mme);
    vec_lim    = (VEC_W + 1)'(1) << log2n;
    req_accept = irq_req && ctl_msi_en && ({1'b0, irq_vec} < vec_lim);
  end

endmodule

// File: rtl/msi_pend_arb.sv
module msi_pend_arb #(
  parameter int VEC_W = 5,
  localparam int NUM_VEC = 1 << VEC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [VEC_W-1:0] set_idx,
  input  logic             take,
  output logic             any_pend,
  output logic [VEC_W-1:0] grant_idx
);

  logic [NUM_VEC-1:0] pending;
  logic [NUM_VEC-1:0] grant;
  logic [NUM_VEC:0]   lower_any;
  logic [NUM_VEC-1:0] set_mask;
  logic [NUM_VEC-1:0] take_mask;

  assign lower_any[0] = 1'b0;

  generate
    for (genvar i = 0; i < NUM_VEC; i++) begin : g_chain
      assign grant[i]         = pending[i] & ~lower_any[i];
      assign lower_any[i + 1] = lower_any[i] | pending[i];
    end
  endgenerate

  assign any_pend  = lower_any[NUM_VEC];
  assign set_mask  = set_en ? (NUM_VEC'(1) << set_idx) : '0;
  assign take_mask = take ? grant : '0;

  always_comb begin
    grant_idx = '0;
    for (int i = 0; i < NUM_VEC; i++)
      if (grant[i]) grant_idx = grant_idx | VEC_W'(i);
  end

  // A new request wins over the clear of the same vector.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending <= '0;
    else        pending <= (pending & ~take_mask) | set_mask;
  end

  assert_grant_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  assert_grant_lowest_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |-> (((grant - NUM_VEC'(1)) & pending) == '0));

  assert_take_has_work_R11: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> any_pend);

endmodule

// File: rtl/msi_wr_port.sv
module msi_wr_port
  import msi_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     launch,
  input  msi_msg_t msg_in,
  input  logic     wr_ready,
  output logic     wr_valid,
  output msi_msg_t msg_out,
  output logic     slot_free
);

  assign slot_free = !wr_valid || wr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      msg_out  <= '0;
    end else if (launch) begin
      wr_valid <= 1'b1;
      msg_out  <= msg_in;
    end else if (wr_ready) begin
      wr_valid <= 1'b0;
    end
  end

  assert_hold_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(msg_out)));

  assert_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (msg_out.data[31:16] == 16'd0));

endmodule

// File: rtl/msi_msg_gen.sv
module msi_msg_gen
  import msi_pkg::*;
#(
  parameter int VEC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_msi_en,
  input  logic             ctl_addr64,
  input  logic [2:0]       ctl_mme,
  input  logic [31:0]      msg_addr_lo,
  input  logic [31:0]      msg_addr_hi,
  input  logic [15:0]      cap_data_w8,
  input  logic [15:0]      cap_data_w12,
  input  logic             irq_req,
  input  logic [VEC_W-1:0] irq_vec,
  output logic             wr_valid,
  input  logic             wr_ready,
  output logic [63:0]      wr_addr,
  output logic [31:0]      wr_data,
  output logic             wr_is64
);

  localparam int L2_W = $clog2(VEC_W + 1);

  logic [L2_W-1:0]  log2n;
  logic [VEC_W:0]   vec_lim;
  logic             req_accept;
  logic             any_pend;
  logic [VEC_W-1:0] grant_idx;
  logic             slot_free;
  logic             launch;
  msi_msg_t         next_msg;
  msi_msg_t         cur_msg;

  msi_cap_decode #(.VEC_W(VEC_W)) u_dec (
    .ctl_msi_en (ctl_msi_en),
    .ctl_mme    (ctl_mme),
    .irq_req    (irq_req),
    .irq_vec    (irq_vec),
    .log2n      (log2n),
    .vec_lim    (vec_lim),
    .req_accept (req_accept)
  );

  msi_pend_arb #(.VEC_W(VEC_W)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_en    (req_accept),
    .set_idx   (irq_vec),
    .take      (launch),
    .any_pend  (any_pend),
    .grant_idx (grant_idx)
  );

  assign launch   = ctl_msi_en && any_pend && slot_free;
  assign next_msg = msi_form(ctl_addr64, msg_addr_lo, msg_addr_hi,
                             cap_data_w8, cap_data_w12, 32'(log2n),
                             16'(grant_idx));

  msi_wr_port u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (launch),
    .msg_in    (next_msg),
    .wr_ready  (wr_ready),
    .wr_valid  (wr_valid),
    .msg_out   (cur_msg),
    .slot_free (slot_free)
  );

  assign wr_addr = cur_msg.addr;
  assign wr_data = cur_msg.data;
  assign wr_is64 = cur_msg.is64;

  assert_addr_narrow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_is64) |-> (wr_addr[63:32] == 32'd0));

  assert_accept_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept |-> ({1'b0, irq_vec} < vec_lim));

  assert_no_send_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> $past(ctl_msi_en));

endmodule

// File: tb/msi_msg_gen_test.sv
module msi_msg_gen_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_msi_en = 1'b0, ctl_addr64 = 1'b0;
  logic [2:0]  ctl_mme = 3'd0;
  logic [31:0] msg_addr_lo = '0, msg_addr_hi = '0;
  logic [15:0] cap_data_w8 = '0, cap_data_w12 = '0;
  logic        irq_req = 1'b0;
  logic [4:0]  irq_vec = '0;
  logic        wr_valid, wr_ready = 1'b0, wr_is64;
  logic [63:0] wr_addr;
  logic [31:0] wr_data;

  always #5 clk = ~clk;

  msi_msg_gen uut (
    .clk(clk), .rst_n(rst_n), .ctl_msi_en(ctl_msi_en), .ctl_addr64(ctl_addr64),
    .ctl_mme(ctl_mme), .msg_addr_lo(msg_addr_lo), .msg_addr_hi(msg_addr_hi),
    .cap_data_w8(cap_data_w8), .cap_data_w12(cap_data_w12), .irq_req(irq_req),
    .irq_vec(irq_vec), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_is64(wr_is64)
  );

  int checks = 0, fails = 0, cycles = 0;
  int req_v[8];
  int nreq;

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic int vec_count(input int mme);
    int k;
    k = (mme > 5) ? 5 : mme;
    return 1 << k;
  endfunction

  function automatic logic [31:0] exp_data(input int v);
    int n, d;
    n = vec_count(int'(ctl_mme));
    d = ctl_addr64 ? int'(cap_data_w12) : int'(cap_data_w8);
    return 32'((d / n) * n + v);
  endfunction

  // Case: first request is outstanding under stall, the rest pile up behind it.
  task automatic run_case(input bit en, input bit a64, input int mme, input string cnt_tag);
    int exp_v[40];
    int n_exp, n, got, t, extra;
    bit [31:0] rest;
    bit stalled;
    logic [63:0] s_addr;
    logic [31:0] s_data;
    logic s_is64;
    string dtag;
    @(negedge clk);
    wr_ready     = 1'b0;
    ctl_msi_en   = en;
    ctl_addr64   = a64;
    ctl_mme      = 3'(mme);
    msg_addr_lo  = $urandom;
    msg_addr_hi  = $urandom;
    cap_data_w8  = 16'($urandom);
    cap_data_w12 = 16'($urandom);
    n = vec_count(mme);
    n_exp = 0;
    rest = '0;
    if (en && req_v[0] < n) begin exp_v[0] = req_v[0]; n_exp = 1; end
    for (int i = 1; i < nreq; i++) if (en && req_v[i] < n) rest[req_v[i]] = 1'b1;
    for (int v = 0; v < 32; v++) if (rest[v]) begin exp_v[n_exp] = v; n_exp++; end
    if (mme > 5) dtag = "R5"; else if (n > 1) dtag = "R6"; else dtag = "R7";

    @(negedge clk); irq_req = 1'b1; irq_vec = 5'(req_v[0]);
    @(negedge clk); irq_req = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 1; i < nreq; i++) begin
      irq_req = 1'b1; irq_vec = 5'(req_v[i]);
      @(negedge clk);
    end
    irq_req = 1'b0;
    repeat (2) @(negedge clk);

    got = 0; t = 0; stalled = 1'b0;
    s_addr = '0; s_data = '0; s_is64 = 1'b0;
    while (got < n_exp && t < 300) begin
      wr_ready = ($urandom % 3) != 0;
      #1;
      if (stalled)
        check(wr_valid && wr_addr == s_addr && wr_data == s_data && wr_is64 == s_is64,
              "R10", "held message", {wr_valid, wr_data[30:0], wr_addr[31:0]},
              {1'b1, s_data[30:0], s_addr[31:0]});
      stalled = 1'b0;
      if (wr_valid) begin
        if (wr_ready) begin
          if (a64)
            check(wr_addr == {msg_addr_hi, msg_addr_lo} && wr_is64, "R3", "address",
                  wr_addr, {msg_addr_hi, msg_addr_lo});
          else
            check(wr_addr == {32'd0, msg_addr_lo} && !wr_is64, "R4", "address",
                  wr_addr, {32'd0, msg_addr_lo});
          check(wr_data == exp_data(exp_v[got]), dtag, "data (order R12)",
                64'(wr_data), 64'(exp_data(exp_v[got])));
          check(wr_data[31:16] == 16'd0, "R9", "upper data", 64'(wr_data[31:16]), 64'd0);
          got++;
        end else begin
          stalled = 1'b1;
          s_addr = wr_addr; s_data = wr_data; s_is64 = wr_is64;
        end
      end
      @(negedge clk);
      t++;
    end
    wr_ready = 1'b1;
    extra = 0;
    repeat (10) begin
      #1;
      if (wr_valid) extra++;
      @(negedge clk);
    end
    check(got == n_exp && extra == 0, cnt_tag, "message count",
          64'(got + extra), 64'(n_exp));
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(wr_valid == 1'b0, "R1", "wr_valid in reset", 64'(wr_valid), 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(wr_valid == 1'b0, "R1", "wr_valid after reset", 64'(wr_valid), 64'd0);

    nreq = 2; req_v[0] = 0; req_v[1] = 3;
    run_case(1'b0, 1'b0, 2, "R2");
    nreq = 1; req_v[0] = 0;
    run_case(1'b1, 1'b0, 0, "R7");
    nreq = 1; req_v[0] = 1;
    run_case(1'b1, 1'b1, 0, "R8");
    nreq = 5; req_v[0] = 2; req_v[1] = 7; req_v[2] = 1; req_v[3] = 7; req_v[4] = 5;
    run_case(1'b1, 1'b1, 3, "R11");
    nreq = 3; req_v[0] = 31; req_v[1] = 30; req_v[2] = 0;
    run_case(1'b1, 1'b1, 7, "R5");
    nreq = 4; req_v[0] = 1; req_v[1] = 4; req_v[2] = 9; req_v[3] = 3;
    run_case(1'b1, 1'b0, 2, "R8");
    nreq = 3; req_v[0] = 0; req_v[1] = 31; req_v[2] = 16;
    run_case(1'b1, 1'b0, 6, "R12");
    nreq = 2; req_v[0] = 3; req_v[1] = 3;
    run_case(1'b1, 1'b1, 2, "R11");

    for (int c = 0; c < 150; c++) begin
      int mme, n;
      bit en;
      en = ($urandom % 8) != 0;
      mme = int'($urandom % 8);
      n = vec_count(mme);
      nreq = 1 + int'($urandom % 6);
      req_v[0] = int'($urandom % n);
      for (int i = 1; i < nreq; i++) req_v[i] = int'($urandom % 32);
      run_case(en, 1'($urandom), mme, en ? "R12" : "R2");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule